// File: doc/BRIEF.md
# FSK Modem Transmit Task Sequencer

This block runs a four-level FSK transmitter one task at a time. Time is counted in symbol periods, and each period is marked by a one-clock `sym_stb` pulse. The host first places the task's data in a byte buffer and then writes a task code. The block takes a copy of the buffer when it accepts the task. It then drives one 2-bit symbol on `tx_sym` per strobe and reports on `bfree` when the host may load the next task. Raw tasks turn bytes straight into dibits. Block tasks only set up the fixed 66-symbol slot: they hand the bytes to an external encoder and forward that encoder's symbols.

The host keeps the transmitter busy by writing the next task after `bfree` rises and before the current task's last symbol ends. If no task is waiting when a task ends, the line falls back to a fixed idle symbol and a sticky underrun flag is raised. The RESET code stops everything at once.

Task codes on `task_code`: 0 RESET, 1 raw 24-symbol, 2 header block, 3 intermediate block, 4 last block, 5 raw 4-symbol. Codes 6 and 7 are invalid.

Top module: `fsk_tx_seq`

## Requirements
- R1: After `rst_n` is low on a clock edge, `bfree` is 1, `irq`, `underrun` and `wr_err` are 0, and `tx_sym` holds the idle symbol (parameter `IDLE_SYM`, default 2'b01).
- R2: A task accepted while the transmitter is idle puts out the idle symbol on the first strobe after the write. Its first symbol appears on the second strobe.
- R3: The raw 24-symbol task (code 1) sends bytes 0 to 5 of `buf_data`, where byte i is bits [8i+7:8i]. Bytes go in ascending order, and each byte is sent as four dibits starting with bits [7:6]. The raw 4-symbol task (code 5) sends byte 0 the same way, as exactly 4 symbols.
- R4: A block task (codes 2, 3, 4) lasts 66 strobes. On each of them `enc_step` is high and `tx_sym` takes the value of `enc_sym`. On its first strobe `enc_load` pulses, `enc_kind` is 0, 1 or 2 for header, intermediate or last, and `enc_bytes` carries the 12 buffer bytes. For the last block only the low 8 bytes are passed and the upper 32 bits are zero.
- R5: `bfree` and `irq` both become 1 on the strobe that applies symbol index 5 (raw 24-symbol task), symbol 16 (block tasks) or symbol 0 (raw 4-symbol task), counting from 0.
- R6: An accepted task write clears `bfree` on the next clock. `bfree` stays 0 while a task is waiting to start.
- R7: If the next task is written before the current task's last symbol period ends, that task's first symbol follows on the very next strobe, with no idle symbol and no underrun.
- R8: If no task is waiting when the last symbol period ends, the next strobe puts out the idle symbol and sets `underrun`.
- R9: Writing code 0 (RESET) is accepted whatever the state of `bfree`. On the next clock, with no strobe needed, the running and waiting tasks are dropped, `tx_sym` is the idle symbol and `bfree` is 1. `irq` keeps its value.
- R10: A task write while `bfree` is 0, or with code 6 or 7, is ignored and sets `wr_err`. An ignored task never produces symbols.
- R11: A pulse on `stat_rd` clears `irq`, `underrun` and `wr_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sym_stb | input | 1 | One-clock pulse per symbol period |
| task_wr | input | 1 | Task code write strobe |
| task_code | input | 3 | Task code |
| buf_data | input | 96 | Data buffer contents, byte i at [8i+7:8i] |
| stat_rd | input | 1 | Status read pulse, clears the sticky flags |
| enc_sym | input | 2 | Symbol from the block encoder |
| tx_sym | output | 2 | Transmit symbol |
| bfree | output | 1 | Host may write the next task and data |
| irq | output | 1 | Buffer has been consumed |
| underrun | output | 1 | Idle gap after a task (sticky) |
| wr_err | output | 1 | Rejected task write (sticky) |
| enc_step | output | 1 | Encoder symbol taken on this strobe |
| enc_load | output | 1 | New block handed to the encoder |
| enc_kind | output | 2 | Block kind: 0 header, 1 intermediate, 2 last |
| enc_bytes | output | 96 | Block bytes for the encoder |

## Verification
Assertions check on every cycle that an accepted write or a waiting task holds `bfree` low. They also check that RESET restores the idle symbol and `bfree` while keeping `irq`, that `irq` never rises without `bfree`, that the symbol count never passes the task's length, that a new underrun always comes with the idle symbol, and that a status read clears `irq`. Only the bench's scenarios can show the content and order of the symbols, the exact strobe at which the buffer is released for each task type, the two-strobe start from idle, gap-free chaining, and that rejected writes never turn into symbols.

// File: rtl/fsk_tx_pkg.sv
// Shared task codes, slot lengths and decode record for the FSK transmit
// task sequencer. Assumes the 3-bit task code layout used by the host.
package fsk_tx_pkg;
    localparam logic [2:0] OP_RESET = 3'd0;
    localparam logic [2:0] OP_RAW24 = 3'd1;
    localparam logic [2:0] OP_HDR   = 3'd2;
    localparam logic [2:0] OP_MID   = 3'd3;
    localparam logic [2:0] OP_LAST  = 3'd4;
    localparam logic [2:0] OP_RAW4  = 3'd5;

    localparam int RAW24_SYMS = 24;
    localparam int BLK_SYMS   = 66;
    localparam int RAW4_SYMS  = 4;
    localparam int RAW24_FREE = 5;
    localparam int BLK_FREE   = 16;
    localparam int RAW4_FREE  = 0;
    localparam int LAST_BYTES = 8;
    localparam int SYM_W      = $clog2(BLK_SYMS + 1);

    localparam logic [1:0] KIND_HDR  = 2'd0;
    localparam logic [1:0] KIND_MID  = 2'd1;
    localparam logic [1:0] KIND_LAST = 2'd2;

    typedef struct packed {
        logic             ok;
        logic             blk;
        logic [SYM_W-1:0] len;
        logic [SYM_W-1:0] rel;
        logic [1:0]       kind;
    } op_info_t;
endpackage

// File: rtl/fsk_tx_op_decode.sv
// Task code decoder: gives slot length, release symbol index, block flag
// and block kind for a task code. Assumes RESET is handled by the caller
// (it decodes as not ok, like the invalid codes).
module fsk_tx_op_decode
    import fsk_tx_pkg::*;
(
    input  logic [2:0] code,
    output op_info_t   info
);
    // Map each task code to its timing record.
    always_comb begin
        info = '0;
        unique case (code)
            OP_RAW24: begin
                info.ok  = 1'b1;
                info.len = SYM_W'(RAW24_SYMS);
                info.rel = SYM_W'(RAW24_FREE);
            end
            OP_HDR, OP_MID, OP_LAST: begin
                info.ok   = 1'b1;
                info.blk  = 1'b1;
                info.len  = SYM_W'(BLK_SYMS);
                info.rel  = SYM_W'(BLK_FREE);
                info.kind = (code == OP_HDR) ? KIND_HDR :
                            (code == OP_MID) ? KIND_MID : KIND_LAST;
            end
            OP_RAW4: begin
                info.ok  = 1'b1;
                info.len = SYM_W'(RAW4_SYMS);
                info.rel = SYM_W'(RAW4_FREE);
            end
            default: info = '0;
        endcase
    end
endmodule

// File: rtl/fsk_tx_dibit_pick.sv
// Selects one dibit from a byte array: byte idx/4, dibit idx%4 counted
// from the most significant pair. Assumes idx < 4*NBYTES when used.
module fsk_tx_dibit_pick #(
    parameter int NBYTES = 6,
    parameter int IDX_W  = $clog2(NBYTES * 4)
) (
    input  logic [8*NBYTES-1:0] bytes,
    input  logic [IDX_W-1:0]    idx,
    output logic [1:0]          sym
);
    logic [7:0] sel_byte;

    // Pick the byte, then the dibit within it, MSB pair first.
    always_comb begin
        sel_byte = '0;
        for (int i = 0; i < NBYTES; i++) begin
            if (idx[IDX_W-1:2] == i[IDX_W-3:0]) sel_byte = bytes[i*8 +: 8];
        end
        case (idx[1:0])
            2'd0:    sym = sel_byte[7:6];
            2'd1:    sym = sel_byte[5:4];
            2'd2:    sym = sel_byte[3:2];
            default: sym = sel_byte[1:0];
        endcase
    end
endmodule

// File: rtl/fsk_tx_status.sv
// Host-visible status: buffer-free, interrupt and sticky error flags.
// Assumes take and rel_pt never coincide (take needs bfree high).
module fsk_tx_status (
    input  logic clk,
    input  logic rst_n,
    input  logic take,
    input  logic rel_pt,
    input  logic abort,
    input  logic stat_rd,
    input  logic bad_wr,
    input  logic gap,
    output logic bfree,
    output logic irq,
    output logic underrun,
    output logic wr_err
);
    // Buffer ownership: freed by release or abort, taken by a write.
    always_ff @(posedge clk) begin
        if (!rst_n)                bfree <= 1'b1;
        else if (abort || rel_pt)  bfree <= 1'b1;
        else if (take)             bfree <= 1'b0;
    end

    // Sticky flags: set events win over the clearing status read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq      <= 1'b0;
            underrun <= 1'b0;
            wr_err   <= 1'b0;
        end else begin
            if (rel_pt)       irq <= 1'b1;
            else if (stat_rd) irq <= 1'b0;
            if (gap)          underrun <= 1'b1;
            else if (stat_rd) underrun <= 1'b0;
            if (bad_wr)       wr_err <= 1'b1;
            else if (stat_rd) wr_err <= 1'b0;
        end
    end

    a_r11_read_clears_irq: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd && !rel_pt |=> !irq);
    a_r5_irq_with_free: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> bfree);
endmodule

// File: rtl/fsk_tx_seq.sv
// FSK transmit task sequencer top. Accepts host task writes, holds one
// waiting task, steps the active task once per symbol strobe, emits raw
// dibits or forwards encoder symbols, and drives the host status bits.
// Assumes sym_stb is a single-clock pulse and the buffer is stable at the
// task write.
module fsk_tx_seq
    import fsk_tx_pkg::*;
#(
    parameter int         BUF_BYTES = 12,
    parameter int         RAW_BYTES = 6,
    parameter logic [1:0] IDLE_SYM  = 2'b01
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   sym_stb,
    input  logic                   task_wr,
    input  logic [2:0]             task_code,
    input  logic [8*BUF_BYTES-1:0] buf_data,
    input  logic                   stat_rd,
    input  logic [1:0]             enc_sym,
    output logic [1:0]             tx_sym,
    output logic                   bfree,
    output logic                   irq,
    output logic                   underrun,
    output logic                   wr_err,
    output logic                   enc_step,
    output logic                   enc_load,
    output logic [1:0]             enc_kind,
    output logic [8*BUF_BYTES-1:0] enc_bytes
);
    localparam int DW     = 8 * BUF_BYTES;
    localparam int PICK_W = $clog2(RAW_BYTES * 4);
    localparam int NDEC   = 3;

    logic             act_v, pend_v, prep;
    logic [2:0]       act_code, pend_code;
    logic [DW-1:0]    act_data, pend_data;
    logic [SYM_W-1:0] idx;
    logic [1:0]       act_sym, pend_sym;
    logic [DW-1:0]    blk_bytes;

    logic [2:0] dec_code [NDEC];
    op_info_t   dec_info [NDEC];
    op_info_t   wr_info, act_info, pend_info;

    assign dec_code[0] = task_code;
    assign dec_code[1] = act_code;
    assign dec_code[2] = pend_code;

    // One decoder each for the written, active and waiting task codes.
    for (genvar g = 0; g < NDEC; g++) begin : g_dec
        fsk_tx_op_decode u_dec (
            .code (dec_code[g]),
            .info (dec_info[g])
        );
    end

    assign wr_info   = dec_info[0];
    assign act_info  = dec_info[1];
    assign pend_info = dec_info[2];

    fsk_tx_dibit_pick #(.NBYTES(RAW_BYTES)) u_act_pick (
        .bytes (act_data[8*RAW_BYTES-1:0]),
        .idx   (idx[PICK_W-1:0]),
        .sym   (act_sym)
    );

    fsk_tx_dibit_pick #(.NBYTES(RAW_BYTES)) u_pend_pick (
        .bytes (pend_data[8*RAW_BYTES-1:0]),
        .idx   ('0),
        .sym   (pend_sym)
    );

    // Host write classification.
    logic reset_cmd, wr_ok, wr_bad;
    assign reset_cmd = task_wr && (task_code == OP_RESET);
    assign wr_ok     = task_wr && !reset_cmd && wr_info.ok && bfree;
    assign wr_bad    = task_wr && !reset_cmd && !(wr_info.ok && bfree);

    // Strobe-time decisions.
    logic go_run, more, chain, arm, finish, rel_pt;
    assign go_run   = sym_stb && !reset_cmd;
    assign more     = act_v && (idx < act_info.len);
    assign chain    = go_run && !more && pend_v && (act_v || prep);
    assign arm      = go_run && !more && pend_v && !act_v && !prep;
    assign finish   = go_run && !more && act_v && !pend_v;
    assign rel_pt   = go_run && ((more && (idx == act_info.rel)) ||
                                 (chain && (pend_info.rel == '0)));
    assign enc_step = go_run && ((more && act_info.blk) || (chain && pend_info.blk));

    // Bytes handed to the encoder: the last block passes only its data bytes.
    always_comb begin
        for (int i = 0; i < BUF_BYTES; i++) begin
            blk_bytes[i*8 +: 8] = (pend_info.kind == KIND_LAST && i >= LAST_BYTES)
                                  ? 8'h00 : pend_data[i*8 +: 8];
        end
    end

    // Task pipeline: waiting slot, start-up stroke, active slot and symbol out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_v     <= 1'b0;
            pend_v    <= 1'b0;
            prep      <= 1'b0;
            act_code  <= '0;
            pend_code <= '0;
            act_data  <= '0;
            pend_data <= '0;
            idx       <= '0;
            tx_sym    <= IDLE_SYM;
            enc_load  <= 1'b0;
            enc_kind  <= '0;
            enc_bytes <= '0;
        end else if (reset_cmd) begin
            act_v    <= 1'b0;
            pend_v   <= 1'b0;
            prep     <= 1'b0;
            idx      <= '0;
            tx_sym   <= IDLE_SYM;
            enc_load <= 1'b0;
        end else begin
            enc_load <= 1'b0;
            if (wr_ok) begin
                pend_v    <= 1'b1;
                pend_code <= task_code;
                pend_data <= buf_data;
            end
            if (go_run) begin
                if (more) begin
                    tx_sym <= act_info.blk ? enc_sym : act_sym;
                    idx    <= idx + 1'b1;
                end else if (chain) begin
                    act_v    <= 1'b1;
                    act_code <= pend_code;
                    act_data <= pend_data;
                    idx      <= SYM_W'(1);
                    pend_v   <= 1'b0;
                    prep     <= 1'b0;
                    tx_sym   <= pend_info.blk ? enc_sym : pend_sym;
                    if (pend_info.blk) begin
                        enc_load  <= 1'b1;
                        enc_kind  <= pend_info.kind;
                        enc_bytes <= blk_bytes;
                    end
                end else if (arm) begin
                    prep   <= 1'b1;
                    tx_sym <= IDLE_SYM;
                end else begin
                    act_v  <= 1'b0;
                    tx_sym <= IDLE_SYM;
                end
            end
        end
    end

    fsk_tx_status u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (wr_ok),
        .rel_pt   (rel_pt),
        .abort    (reset_cmd),
        .stat_rd  (stat_rd),
        .bad_wr   (wr_bad),
        .gap      (finish),
        .bfree    (bfree),
        .irq      (irq),
        .underrun (underrun),
        .wr_err   (wr_err)
    );

    a_r6_write_takes_buffer: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ok |=> !bfree);
    a_r6_waiting_holds_buffer: assert property (@(posedge clk) disable iff (!rst_n)
        pend_v |-> !bfree);
    a_r9_reset_frees: assert property (@(posedge clk) disable iff (!rst_n)
        reset_cmd |=> bfree && (tx_sym == IDLE_SYM) && !act_v && !pend_v);
    a_r9_reset_keeps_irq: assert property (@(posedge clk) disable iff (!rst_n)
        reset_cmd && !stat_rd |=> irq == $past(irq));
    a_r4_slot_bound: assert property (@(posedge clk) disable iff (!rst_n)
        act_v |-> idx <= act_info.len);
    a_r8_gap_idles: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(underrun) |-> tx_sym == IDLE_SYM);
endmodule

// File: tb/sim_fsk_tx_seq.sv
module sim_fsk_tx_seq;
    localparam logic [1:0] IDLE = 2'b01;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sym_stb = 1'b0;
    logic        task_wr = 1'b0;
    logic [2:0]  task_code = '0;
    logic [95:0] buf_data = '0;
    logic        stat_rd = 1'b0;
    logic [1:0]  enc_sym = '0;
    logic [1:0]  tx_sym;
    logic        bfree, irq, underrun, wr_err, enc_step, enc_load;
    logic [1:0]  enc_kind;
    logic [95:0] enc_bytes;

    int checks = 0;
    int errors = 0;
    logic step_enc;

    always #4 clk = ~clk;

    fsk_tx_seq u0 (
        .clk(clk), .rst_n(rst_n), .sym_stb(sym_stb), .task_wr(task_wr),
        .task_code(task_code), .buf_data(buf_data), .stat_rd(stat_rd),
        .enc_sym(enc_sym), .tx_sym(tx_sym), .bfree(bfree), .irq(irq),
        .underrun(underrun), .wr_err(wr_err), .enc_step(enc_step),
        .enc_load(enc_load), .enc_kind(enc_kind), .enc_bytes(enc_bytes)
    );

    typedef struct packed {
        logic [2:0]  code;
        logic [6:0]  len;
        logic [6:0]  rel;
        logic        blk;
        logic [1:0]  kind;
        logic [95:0] data;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VEC [NV] = '{
        '{3'd1, 7'd24, 7'd5,  1'b0, 2'd0, 96'h0000_0000_0000_F0A5_C8D4_2E1B},
        '{3'd5, 7'd4,  7'd0,  1'b0, 2'd0, 96'h0000_0000_0000_0000_0000_00B4},
        '{3'd2, 7'd66, 7'd16, 1'b1, 2'd0, 96'h0123_4567_89AB_CDEF_0F1E_2D3C},
        '{3'd3, 7'd66, 7'd16, 1'b1, 2'd1, 96'hA1B2_C3D4_E5F6_0718_293A_4B5C},
        '{3'd4, 7'd66, 7'd16, 1'b1, 2'd2, 96'hDEAD_BEEF_1122_3344_5566_7788},
        '{3'd1, 7'd24, 7'd5,  1'b0, 2'd0, 96'hFFEE_DDCC_BBAA_9988_7766_5544},
        '{3'd5, 7'd4,  7'd0,  1'b0, 2'd0, 96'h0000_0000_0000_0000_0000_0027}
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        sym_stb = 1'b1;
        #1 step_enc = enc_step;
        @(negedge clk);
        sym_stb = 1'b0;
    endtask

    task automatic wr(input logic [2:0] c);
        @(negedge clk);
        task_wr = 1'b1;
        task_code = c;
        @(negedge clk);
        task_wr = 1'b0;
    endtask

    task automatic rd_stat();
        @(negedge clk);
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
    endtask

    function automatic logic [1:0] dib(input logic [95:0] d, input int s);
        logic [7:0] b;
        b = d[8*(s/4) +: 8];
        return 2'((b >> (6 - 2*(s%4))) & 8'h3);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(bfree == 1'b1, "R1", "bfree", bfree, 1);
        chk(irq == 1'b0, "R1", "irq", irq, 0);
        chk(underrun == 1'b0 && wr_err == 1'b0, "R1", "flags", {underrun, wr_err}, 0);
        chk(tx_sym == IDLE, "R1", "tx_sym", tx_sym, IDLE);

        // Vector table walk: one task per entry, started from idle.
        for (int v = 0; v < NV; v++) begin
            int rel_seen;
            logic [95:0] exp_bytes;
            wr(3'd0);
            rd_stat();
            buf_data = VEC[v].data;
            wr(VEC[v].code);
            chk(bfree == 1'b0, "R6", "bfree after write", bfree, 0);
            step();
            chk(tx_sym == IDLE, "R2", "start-up symbol", tx_sym, IDLE);
            rel_seen = -1;
            exp_bytes = (VEC[v].kind == 2'd2) ? {32'h0, VEC[v].data[63:0]} : VEC[v].data;
            for (int s = 0; s < int'(VEC[v].len); s++) begin
                logic [1:0] e;
                enc_sym = 2'(s) ^ 2'b10;
                step();
                if (VEC[v].blk) begin
                    e = 2'(s) ^ 2'b10;
                    chk(tx_sym == e, "R4", "block symbol", tx_sym, e);
                    chk(step_enc == 1'b1, "R4", "enc_step", step_enc, 1);
                    if (s == 0) begin
                        chk(enc_load == 1'b1, "R4", "enc_load", enc_load, 1);
                        chk(enc_kind == VEC[v].kind, "R4", "enc_kind", enc_kind, VEC[v].kind);
                        chk(enc_bytes == exp_bytes, "R4", "enc_bytes", enc_bytes, exp_bytes);
                    end
                end else begin
                    e = dib(VEC[v].data, s);
                    chk(tx_sym == e, "R3", "raw symbol", tx_sym, e);
                end
                if (bfree && rel_seen < 0) rel_seen = s;
            end
            chk(rel_seen == int'(VEC[v].rel), "R5", "release index", rel_seen, VEC[v].rel);
            chk(irq == 1'b1, "R5", "irq", irq, 1);
            step();
            chk(tx_sym == IDLE, "R8", "idle after end", tx_sym, IDLE);
            chk(underrun == 1'b1, "R8", "underrun", underrun, 1);
        end

        // R11: status read clears the sticky flags
        rd_stat();
        chk(irq == 1'b0, "R11", "irq cleared", irq, 0);
        chk(underrun == 1'b0, "R11", "underrun cleared", underrun, 0);

        // R10: invalid code ignored
        wr(3'd6);
        chk(wr_err == 1'b1, "R10", "wr_err on invalid code", wr_err, 1);
        chk(bfree == 1'b1, "R10", "bfree kept", bfree, 1);
        for (int k = 0; k < 3; k++) begin
            step();
            chk(tx_sym == IDLE, "R10", "no start after invalid", tx_sym, IDLE);
        end
        rd_stat();
        chk(wr_err == 1'b0, "R11", "wr_err cleared", wr_err, 0);

        // R10: write while busy is ignored and never queued
        buf_data = VEC[0].data;
        wr(3'd1);
        buf_data = 96'h9C;
        wr(3'd5);
        chk(wr_err == 1'b1, "R10", "wr_err on busy write", wr_err, 1);
        step();
        for (int s = 0; s < 24; s++) step();
        step();
        chk(tx_sym == IDLE, "R10", "ignored task not sent", tx_sym, IDLE);
        chk(underrun == 1'b1, "R10", "underrun after lone task", underrun, 1);
        rd_stat();

        // R7: chained raw 4-symbol tasks
        buf_data = 96'hB4;
        wr(3'd5);
        step();
        step();
        chk(bfree == 1'b1, "R5", "bfree on first raw4 symbol", bfree, 1);
        buf_data = 96'h9C;
        wr(3'd5);
        for (int s = 1; s < 4; s++) step();
        chk(tx_sym == dib(96'hB4, 3), "R7", "last symbol of first", tx_sym, dib(96'hB4, 3));
        for (int s = 0; s < 4; s++) begin
            step();
            chk(tx_sym == dib(96'h9C, s), "R7", "chained symbol", tx_sym, dib(96'h9C, s));
        end
        chk(underrun == 1'b0, "R7", "no underrun when chained", underrun, 0);
        step();
        chk(underrun == 1'b1 && tx_sym == IDLE, "R8", "gap after chain", {underrun, tx_sym}, {1'b1, IDLE});

        // R9: RESET mid-task with irq already set
        chk(irq == 1'b1, "R9", "irq set before", irq, 1);
        rd_stat();
        buf_data = VEC[5].data;
        wr(3'd1);
        step();
        for (int s = 0; s < 3; s++) step();
        chk(bfree == 1'b0, "R9", "bfree low mid-task", bfree, 0);
        chk(irq == 1'b0, "R9", "irq low mid-task", irq, 0);
        wr(3'd0);
        chk(bfree == 1'b1, "R9", "bfree after reset", bfree, 1);
        chk(tx_sym == IDLE, "R9", "idle after reset", tx_sym, IDLE);
        chk(irq == 1'b0, "R9", "irq kept low", irq, 0);
        step();
        chk(tx_sym == IDLE && underrun == 1'b0, "R9", "task dropped", {underrun, tx_sym}, {1'b0, IDLE});

        // R9: RESET keeps irq high
        buf_data = 96'hB4;
        wr(3'd5);
        step();
        step();
        buf_data = VEC[0].data;
        wr(3'd1);
        chk(irq == 1'b1, "R9", "irq high before reset", irq, 1);
        wr(3'd0);
        chk(irq == 1'b1, "R9", "irq kept high", irq, 1);
        chk(tx_sym == IDLE && bfree == 1'b1, "R9", "abort with waiting task", {bfree, tx_sym}, {1'b1, IDLE});
        step();
        step();
        chk(tx_sym == IDLE, "R9", "waiting task dropped", tx_sym, IDLE);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule